// File: doc/BRIEF.md
# Flash Write Status and Operation Timer

This block is the device-side execution unit of a word-wide flash memory. A command decoder upstream presents the kind of operation it has decoded (word program, whole-array erase or sector erase) together with the data word, while the host toggles the write strobe. The block turns a qualified strobe into a self-timed operation. It keeps a busy flag raised for a fixed, parameterised number of clock cycles, then reports the completed operation on a one-cycle done pulse. For a program, the pulse carries the word that the array must store.

While an operation runs, host reads do not return plain array data. Bit 7 carries a polling value and bit 6 carries a toggle that changes once per read access. The other bits pass through from the array. When the timer expires, the block goes back to plain array reads with no action from the host. After power becomes good, a write lockout window refuses every request. A strobe whose low phase is too short is treated as a glitch and starts nothing. The reset input cancels a running operation.

Top module: `fws_unit`

## Requirements
- R1: After reset, `busy`, `done_valid` and `write_ready` are 0. A read (`ce_n` and `oe_n` both low) returns `arr_rdata` unchanged, and `rd_data` is 0 when no read is active.
- R2: `write_ready` rises after exactly LOCK_CYC rising clock edges with `pwr_good` high. It falls one cycle after `pwr_good` is sampled low. Requests made while it is 0 never raise `busy`.
- R3: An operation starts on the clock edge where `we_n` is first sampled high, and only if `we_n` was sampled low on at least MIN_WE_LOW consecutive edges just before it. A shorter low phase starts nothing.
- R4: `cmd_kind` encodes 0 none, 1 word program, 2 whole-array erase, 3 sector erase. A program keeps `busy` high for PROG_CYC cycles. An erase keeps it high for ERASE_CYC cycles. In the cycle after `busy` falls, `done_valid` pulses once, with `done_kind` set to the operation's code.
- R5: For a program, `done_word` equals the array word present on `arr_rdata` at the start edge ANDed with `cmd_wdata`, so bits can only go from 1 to 0. For an erase, `done_word` is all ones.
- R6: While a program runs, a read shows on bit 7 the complement of bit 7 of the word being programmed.
- R7: While an erase runs, a read shows 0 on bit 7.
- R8: While busy, bit 6 of a read holds a toggle. The toggle is cleared when the operation starts and inverts once at the beginning of each read access, so the first read shows 1, the second 0, and so on. It does not change within one read. Bits 15:8 and 5:0 come from `arr_rdata`.
- R9: A request that arrives while `busy` is high is ignored. The running operation keeps its kind and duration, and only one done pulse follows.
- R10: Driving `rst_n` low during an operation clears `busy` at once, and no done pulse follows. Reads then return array data, and the write lockout window restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; cancels a running operation |
| pwr_good | input | 1 | Supply has reached its sense level |
| we_n | input | 1 | Active-low write strobe |
| cmd_kind | input | 2 | Decoded operation code, sampled at the strobe's rising edge |
| cmd_wdata | input | 16 | Data word for a program |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| arr_rdata | input | 16 | Word read from the array at the current address |
| rd_data | output | 16 | Data returned to the host during a read |
| busy | output | 1 | An operation is running |
| write_ready | output | 1 | Power-up write lockout has ended |
| done_valid | output | 1 | One-cycle pulse when an operation completes |
| done_kind | output | 2 | Code of the completed operation |
| done_word | output | 16 | Word to store (program) or all ones (erase) |

## Verification
Programs are run with written words whose bit 7 is set and with words whose bit 7 is clear, over old array words that overlap them only partly. This separates the inverted polling bit from a copied bit and exposes a merge that ORs or replaces instead of ANDing. Both erase codes are run with array data whose bits 7 and 6 are set, so a mux that leaks array data or forgets to force bit 7 low shows up. Back-to-back reads within one operation, each sampled twice, tell a per-access toggle apart from a per-clock or stuck one. Strobes one cycle short of the minimum, requests inside the power window, a request during a running operation, and a reset in mid-operation each test a path that must leave no trace on `busy` or on the done pulse.

// File: rtl/fws_pkg.sv
package fws_pkg;

  localparam int DW = 16;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PROG = 2'b01,
    OP_CHIP = 2'b10,
    OP_SECT = 2'b11
  } op_kind_e;

  // Programming can only clear bits: the stored word is old AND new.
  function automatic logic [DW-1:0] prog_merge(input logic [DW-1:0] old_w,
                                                input logic [DW-1:0] new_w);
    return old_w & new_w;
  endfunction

  function automatic logic is_erase(input op_kind_e k);
    return (k == OP_CHIP) || (k == OP_SECT);
  endfunction

  // Polling bit shown on bit 7 while busy.
  function automatic logic poll_bit(input op_kind_e k, input logic [DW-1:0] wdata);
    return (k == OP_PROG) ? ~wdata[7] : 1'b0;
  endfunction

  // Busy-time read word: array bits with bits 7 and 6 replaced by status.
  function automatic logic [DW-1:0] status_word(input logic [DW-1:0] arr,
                                                 input logic          dq7,
                                                 input logic          dq6);
    logic [DW-1:0] w;
    w    = arr;
    w[7] = dq7;
    w[6] = dq6;
    return w;
  endfunction

endpackage

// File: rtl/fws_we_filter.sv
module fws_we_filter #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we_n,
  output logic strobe_o
);
  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] LIM = CW'(MIN_LOW);

  logic [CW-1:0] low_cnt;

  // Counts consecutive low samples of the strobe, saturating at the limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (!we_n) begin
      if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
    end else begin
      low_cnt <= '0;
    end
  end

  assign strobe_o = we_n && (low_cnt == LIM);

  a_r3_strobe_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> $past(!we_n));

endmodule

// File: rtl/fws_pwr_lock.sv
module fws_pwr_lock #(
  parameter int LOCK_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic ok_o
);
  localparam int CW = $clog2(LOCK_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      ok_o <= 1'b0;
    end else if (!pwr_good) begin
      cnt  <= '0;
      ok_o <= 1'b0;
    end else if (!ok_o) begin
      if (cnt == LAST) ok_o <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end

  a_r2_lock_on_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !ok_o);

endmodule

// File: rtl/fws_op_timer.sv
module fws_op_timer
  import fws_pkg::*;
#(
  parameter int PROG_CYC  = 5000,
  parameter int ERASE_CYC = 10000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  op_kind_e      kind_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] old_i,
  output logic          busy_o,
  output op_kind_e      op_o,
  output logic [DW-1:0] wdata_o,
  output logic          done_o,
  output op_kind_e      done_kind_o,
  output logic [DW-1:0] done_word_o
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PROG_LAST  = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] ERASE_LAST = CW'(ERASE_CYC - 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] old_q;

  function automatic logic [CW-1:0] last_count(input op_kind_e k);
    return is_erase(k) ? ERASE_LAST : PROG_LAST;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o      <= 1'b0;
      cnt         <= '0;
      op_o        <= OP_NONE;
      wdata_o     <= '0;
      old_q       <= '0;
      done_o      <= 1'b0;
      done_kind_o <= OP_NONE;
      done_word_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o  <= 1'b1;
        cnt     <= last_count(kind_i);
        op_o    <= kind_i;
        wdata_o <= wdata_i;
        old_q   <= old_i;
      end else if (busy_o) begin
        if (cnt == '0) begin
          busy_o      <= 1'b0;
          done_o      <= 1'b1;
          done_kind_o <= op_o;
          done_word_o <= (op_o == OP_PROG) ? prog_merge(old_q, wdata_o) : '1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  a_r4_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r9_op_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(op_o) && $stable(wdata_o)));

  a_r5_prog_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && done_kind_o == OP_PROG) |-> ((done_word_o & ~$past(wdata_o)) == '0));

endmodule

// File: rtl/fws_status_mux.sv
module fws_status_mux
  import fws_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          start_i,
  input  logic          busy_i,
  input  op_kind_e      op_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] arr_i,
  output logic [DW-1:0] rd_data_o
);
  logic rd_act;
  logic rd_q;
  logic rd_begin;
  logic tog;

  assign rd_act   = !ce_n && !oe_n;
  assign rd_begin = rd_act && !rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      tog  <= 1'b0;
    end else begin
      rd_q <= rd_act;
      if (start_i)               tog <= 1'b0;
      else if (busy_i && rd_begin) tog <= ~tog;
    end
  end

  always_comb begin
    if (!rd_act)     rd_data_o = '0;
    else if (busy_i) rd_data_o = status_word(arr_i, poll_bit(op_i, wdata_i), tog);
    else             rd_data_o = arr_i;
  end

  a_r7_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && busy_i && is_erase(op_i)) |-> !rd_data_o[7]);

  a_r8_toggle_per_access: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && rd_act && !rd_q) |=> (tog != $past(tog)));

  a_r8_toggle_steady_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && rd_q && !start_i) |=> $stable(tog));

endmodule

// File: rtl/fws_unit.sv
module fws_unit
  import fws_pkg::*;
#(
  parameter int PROG_CYC   = 5000,
  parameter int ERASE_CYC  = 10000000,
  parameter int LOCK_CYC   = 500000,
  parameter int MIN_WE_LOW = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_good,
  input  logic        we_n,
  input  logic [1:0]  cmd_kind,
  input  logic [15:0] cmd_wdata,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic [15:0] arr_rdata,
  output logic [15:0] rd_data,
  output logic        busy,
  output logic        write_ready,
  output logic        done_valid,
  output logic [1:0]  done_kind,
  output logic [15:0] done_word
);
  logic          strobe;
  logic          start;
  op_kind_e      req_kind;
  op_kind_e      cur_op;
  op_kind_e      fin_kind;
  logic [DW-1:0] cur_wdata;

  assign req_kind = op_kind_e'(cmd_kind);

  fws_we_filter #(.MIN_LOW(MIN_WE_LOW)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_n     (we_n),
    .strobe_o (strobe)
  );

  fws_pwr_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .ok_o     (write_ready)
  );

  assign start = strobe && (req_kind != OP_NONE) && write_ready && !busy;

  fws_op_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .kind_i      (req_kind),
    .wdata_i     (cmd_wdata),
    .old_i       (arr_rdata),
    .busy_o      (busy),
    .op_o        (cur_op),
    .wdata_o     (cur_wdata),
    .done_o      (done_valid),
    .done_kind_o (fin_kind),
    .done_word_o (done_word)
  );

  assign done_kind = fin_kind;

  fws_status_mux u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .start_i   (start),
    .busy_i    (busy),
    .op_i      (cur_op),
    .wdata_i   (cur_wdata),
    .arr_i     (arr_rdata),
    .rd_data_o (rd_data)
  );

  a_r2_start_only_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(write_ready));

  a_r6_prog_poll_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_op == OP_PROG && !ce_n && !oe_n) |-> (rd_data[7] == !cur_wdata[7]));

endmodule

// File: tb/fws_unit_tb_top.sv
`timescale 1ns/1ps
module fws_unit_tb_top;
  localparam int PROG_CYC  = 40;
  localparam int ERASE_CYC = 120;
  localparam int LOCK_CYC  = 30;
  localparam int MIN_LOW   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_good = 1'b0;
  logic        we_n = 1'b1;
  logic [1:0]  cmd_kind = 2'd0;
  logic [15:0] cmd_wdata = 16'h0;
  logic        ce_n = 1'b1;
  logic        oe_n = 1'b1;
  logic [15:0] arr_rdata = 16'h0;
  logic [15:0] rd_data;
  logic        busy;
  logic        write_ready;
  logic        done_valid;
  logic [1:0]  done_kind;
  logic [15:0] done_word;

  always #2 clk = ~clk;

  fws_unit #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .LOCK_CYC(LOCK_CYC),
             .MIN_WE_LOW(MIN_LOW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .we_n(we_n),
    .cmd_kind(cmd_kind), .cmd_wdata(cmd_wdata), .ce_n(ce_n), .oe_n(oe_n),
    .arr_rdata(arr_rdata), .rd_data(rd_data), .busy(busy),
    .write_ready(write_ready), .done_valid(done_valid), .done_kind(done_kind),
    .done_word(done_word)
  );

  typedef struct { logic [1:0] kind; logic [15:0] word; int len; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0;
  int n_bad = 0;
  int blen  = 0;

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Status word predicted from the requirements: bits 7/6 overwritten.
  function automatic logic [15:0] busy_read(input logic [15:0] arr, input logic p7,
                                            input logic t6);
    return (arr & 16'hFF3F) | ({15'd0, p7} << 7) | ({15'd0, t6} << 6);
  endfunction

  task automatic write_cmd(input logic [1:0] k, input logic [15:0] d, input int low);
    @(negedge clk);
    cmd_kind = k; cmd_wdata = d; we_n = 1'b0;
    repeat (low) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    cmd_kind = 2'd0;
  endtask

  task automatic do_read(output logic [15:0] d1, output logic [15:0] d2);
    ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); d1 = rd_data;
    @(negedge clk); d2 = rd_data;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic power_up();
    @(negedge clk);
    pwr_good = 1'b1;
    repeat (LOCK_CYC + 1) @(negedge clk);
  endtask

  // Scoreboard monitor: measures busy length and compares each done pulse.
  always @(negedge clk) begin
    if (!rst_n) begin
      blen = 0;
    end else begin
      if (busy) blen++;
      if (done_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9/R10 unexpected done", {14'd0, done_kind}, 16'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(done_kind == e.kind, "R4 done kind", {14'd0, done_kind}, {14'd0, e.kind});
          check(done_word == e.word, "R5 done word", done_word, e.word);
          check(blen == e.len, "R4 busy length", 16'(blen), 16'(e.len));
        end
        blen = 0;
      end
    end
  end

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog", 16'h0, 16'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] a, b;
    arr_rdata = 16'h1234;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", {15'd0, busy}, 16'h0);
    check(done_valid == 1'b0, "R1 done", {15'd0, done_valid}, 16'h0);
    check(write_ready == 1'b0, "R1 write_ready", {15'd0, write_ready}, 16'h0);
    check(rd_data == 16'h0, "R1 idle bus", rd_data, 16'h0);
    do_read(a, b);
    check(a == 16'h1234, "R1 array read", a, 16'h1234);

    // R2 request with power not good is refused
    write_cmd(2'd1, 16'h0000, MIN_LOW);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R2 refused before power", {15'd0, busy}, 16'h0);

    // R2 window length
    pwr_good = 1'b1;
    repeat (LOCK_CYC - 1) @(negedge clk);
    check(write_ready == 1'b0, "R2 ready one edge early", {15'd0, write_ready}, 16'h0);
    @(negedge clk);
    check(write_ready == 1'b1, "R2 ready at window end", {15'd0, write_ready}, 16'h1);

    // R2 loss of power relocks; request in window refused
    pwr_good = 1'b0;
    @(negedge clk);
    check(write_ready == 1'b0, "R2 relock", {15'd0, write_ready}, 16'h0);
    pwr_good = 1'b1;
    write_cmd(2'd2, 16'h0000, MIN_LOW);
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R2 refused in window", {15'd0, busy}, 16'h0);
    repeat (LOCK_CYC) @(negedge clk);
    check(write_ready == 1'b1, "R2 ready again", {15'd0, write_ready}, 16'h1);

    // R3 glitch strobe
    write_cmd(2'd1, 16'h0000, MIN_LOW - 1);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R3 short strobe ignored", {15'd0, busy}, 16'h0);

    // R4 R5 R6 R8 program with bit 7 set
    arr_rdata = 16'hF0F3;
    exp_q.push_back('{2'd1, 16'hF0F3 & 16'h3C8F, PROG_CYC});
    write_cmd(2'd1, 16'h3C8F, MIN_LOW);
    check(busy == 1'b1, "R3 full strobe starts", {15'd0, busy}, 16'h1);
    arr_rdata = 16'hA5C3;
    do_read(a, b);
    check(a == busy_read(16'hA5C3, 1'b0, 1'b1), "R6 poll first read", a, busy_read(16'hA5C3, 1'b0, 1'b1));
    check(b == a, "R8 steady within read", b, a);
    do_read(a, b);
    check(a == busy_read(16'hA5C3, 1'b0, 1'b0), "R8 second read toggles", a, busy_read(16'hA5C3, 1'b0, 1'b0));
    do_read(a, b);
    check(a == busy_read(16'hA5C3, 1'b0, 1'b1), "R8 third read toggles", a, busy_read(16'hA5C3, 1'b0, 1'b1));
    // R9 request while busy ignored
    write_cmd(2'd2, 16'h0000, MIN_LOW);
    wait_idle();
    do_read(a, b);
    check(a == 16'hA5C3, "R8 plain read after done", a, 16'hA5C3);

    // R5 R6 program with bit 7 clear
    arr_rdata = 16'h0F5A;
    exp_q.push_back('{2'd1, 16'h0F5A & 16'h0055, PROG_CYC});
    write_cmd(2'd1, 16'h0055, MIN_LOW);
    do_read(a, b);
    check(a == busy_read(16'h0F5A, 1'b1, 1'b1), "R6 poll inverted bit clear", a, busy_read(16'h0F5A, 1'b1, 1'b1));
    wait_idle();

    // R7 R4 whole-array erase
    arr_rdata = 16'h00FF;
    exp_q.push_back('{2'd2, 16'hFFFF, ERASE_CYC});
    write_cmd(2'd2, 16'h1234, MIN_LOW);
    do_read(a, b);
    check(a == busy_read(16'h00FF, 1'b0, 1'b1), "R7 erase poll low", a, busy_read(16'h00FF, 1'b0, 1'b1));
    do_read(a, b);
    check(a == busy_read(16'h00FF, 1'b0, 1'b0), "R7 erase toggle", a, busy_read(16'h00FF, 1'b0, 1'b0));
    wait_idle();
    arr_rdata = 16'hFFFF;
    do_read(a, b);
    check(a == 16'hFFFF, "R7 true data after erase", a, 16'hFFFF);

    // R7 sector erase
    arr_rdata = 16'hC0C0;
    exp_q.push_back('{2'd3, 16'hFFFF, ERASE_CYC});
    write_cmd(2'd3, 16'h0000, MIN_LOW);
    do_read(a, b);
    check(a == busy_read(16'hC0C0, 1'b0, 1'b1), "R7 sector poll", a, busy_read(16'hC0C0, 1'b0, 1'b1));
    wait_idle();

    // R10 reset cancels a program
    write_cmd(2'd1, 16'h00FF, MIN_LOW);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy == 1'b0, "R10 busy cleared", {15'd0, busy}, 16'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    arr_rdata = 16'h5AA5;
    do_read(a, b);
    check(a == 16'h5AA5, "R10 array read after cancel", a, 16'h5AA5);
    check(write_ready == 1'b0, "R10 lockout restarted", {15'd0, write_ready}, 16'h0);
    repeat (PROG_CYC + 5) @(negedge clk);
    check(busy == 1'b0, "R10 stays idle", {15'd0, busy}, 16'h0);
    check(exp_q.size() == 0, "R9 all done events seen", 16'(exp_q.size()), 16'h0);
    power_up();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule